// File: doc/BRIEF.md
# Control and Status Register Block for a Frame-Streaming Core

This block is the software-facing register file of a core that streams one video frame at a time. A host reaches it through an AXI4-Lite slave port. On the core side it drives a start request and a framebuffer base address. It takes in pulses that report when the core has accepted a start and when it has finished a frame, a level that shows the core is idle, and a progress word that comes with a one-cycle valid pulse.

Several bits change state when they are accessed. The completion and acceptance flags clear when the control word is read. The interrupt status bits flip when a 1 is written to them. The start request clears when the core takes it, unless automatic restart is on. The progress word comes with a fresh-data flag that clears when it is read. A single level interrupt output is formed from a master enable, per-source enables and the status bits.

Top module: `ctrl_regs_axil`

## Requirements
- R1: A write is accepted once both write address and write data are valid, and gets exactly one write response. A read returns its data with `s_rvalid` in the cycle after `s_arready`. Both responses hold until taken, and every response code is 0 (OKAY).
- R2: Word 0x10 holds the framebuffer base address. It is read/write and byte-enabled by `s_wstrb`, and it drives `frame_base`.
- R3: Writing 1 to bit 0 of word 0x00 raises `core_start`. With bit 7 clear, a `job_taken` pulse drops it at the next edge. Writing 0 to bit 0 has no effect.
- R4: While bit 7 of word 0x00 (auto restart, read/write) is 1, `job_taken` leaves `core_start` set.
- R5: In word 0x00, bit 1 is set by `job_done` and bit 3 is set by `job_taken`. A read of word 0x00 clears both, but a new event in the same cycle wins. Bit 2 reads the `core_idle` input.
- R6: Bit 0 of word 0x04 is the master interrupt enable. Bit 0 of word 0x08 enables the finish source and bit 1 enables the accept source. Both words are read/write.
- R7: In word 0x0C, bit 0 is set by `job_done` and bit 1 is set by `job_taken`, whatever the enables are. Writing 1 to a bit flips it, and an event in the same cycle wins.
- R8: `irq` is registered: one cycle after the enables and status change, it equals master enable AND the OR of (status AND per-source enable). Bit 9 of word 0x00 reads it.
- R9: On a `coord_vld` pulse, `coord_data` is captured into word 0x18 (read-only), and bit 0 of word 0x1C is set. Reading word 0x1C clears that flag unless a new pulse arrives in the same cycle.
- R10: Reserved bits, word 0x14 and unaligned addresses read as zero. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| job_done | input | 1 | Core finished a frame (pulse) |
| job_taken | input | 1 | Core accepted the start (pulse) |
| core_idle | input | 1 | Core is idle (level) |
| coord_data | input | DATA_W | Progress word from the core |
| coord_vld | input | 1 | Progress word valid (pulse) |
| core_start | output | 1 | Start request to the core |
| frame_base | output | DATA_W | Framebuffer base address |
| irq | output | 1 | Level interrupt |

## Verification
The following results appear one edge after the stimulus that causes them:
- register writes, at the edge where the write handshake completes;
- read data, at the edge after `s_arready`;
- start, flag and status updates, at the edge that samples a core pulse.

`irq` comes one edge later still, because it is registered from the status and enable registers.

The bench drives on falling edges and reads responses a moment after the rising edge where they appear. Before it looks at `irq`, it lets one further falling edge pass after a status or enable change. Each clear-on-read effect is checked by a second read that returns the cleared value.

// File: rtl/csr_pkg.sv
package csr_pkg;
  typedef enum logic [2:0] {
    IDX_CTL     = 3'd0,
    IDX_IEN_ALL = 3'd1,
    IDX_IEN_SRC = 3'd2,
    IDX_FLAGS   = 3'd3,
    IDX_BASE    = 3'd4,
    IDX_HOLE    = 3'd5,
    IDX_POS     = 3'd6,
    IDX_POS_NEW = 3'd7
  } csr_idx_e;

  localparam int B_GO    = 0;
  localparam int B_FIN   = 1;
  localparam int B_IDLE  = 2;
  localparam int B_TAKEN = 3;
  localparam int B_AUTO  = 7;
  localparam int B_IRQ   = 9;

  localparam int N_SRC     = 2;
  localparam int SRC_FIN   = 0;
  localparam int SRC_TAKEN = 1;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/csr_axil_port.sv
module csr_axil_port #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [STRB_W-1:0] wr_strb,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data
);
  logic aw_rdy_q, ar_rdy_q, b_vld_q, r_vld_q;
  logic [DATA_W-1:0] r_data_q;

  assign wr_en   = aw_rdy_q && s_awvalid && s_wvalid;
  assign wr_addr = s_awaddr;
  assign wr_data = s_wdata;
  assign wr_strb = s_wstrb;
  assign rd_en   = ar_rdy_q && s_arvalid;
  assign rd_addr = s_araddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_rdy_q <= 1'b0;
      b_vld_q  <= 1'b0;
    end else begin
      aw_rdy_q <= s_awvalid && s_wvalid && !aw_rdy_q && !b_vld_q;
      if (wr_en)         b_vld_q <= 1'b1;
      else if (s_bready) b_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ar_rdy_q <= 1'b0;
      r_vld_q  <= 1'b0;
      r_data_q <= '0;
    end else begin
      ar_rdy_q <= s_arvalid && !ar_rdy_q && !r_vld_q;
      if (rd_en) begin
        r_vld_q  <= 1'b1;
        r_data_q <= rd_data;
      end else if (s_rready) begin
        r_vld_q <= 1'b0;
      end
    end
  end

  assign s_awready = aw_rdy_q;
  assign s_wready  = aw_rdy_q;
  assign s_bvalid  = b_vld_q;
  assign s_arready = ar_rdy_q;
  assign s_rvalid  = r_vld_q;
  assign s_rdata   = r_data_q;
endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [STRB_W-1:0] wr_strb,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              job_done,
  input  logic              job_taken,
  input  logic              core_idle,
  input  logic [DATA_W-1:0] coord_data,
  input  logic              coord_vld,
  input  logic              irq,
  output logic              core_start,
  output logic [DATA_W-1:0] frame_base,
  output logic              gie,
  output logic [N_SRC-1:0]  ier,
  output logic [N_SRC-1:0]  isr
);
  function automatic logic addr_hit(input logic [ADDR_W-1:0] a);
    return (a[1:0] == 2'b00) && ((a >> 5) == '0);
  endfunction

  csr_idx_e widx, ridx;
  logic whit, rhit;
  assign widx = csr_idx_e'(wr_addr[4:2]);
  assign ridx = csr_idx_e'(rd_addr[4:2]);
  assign whit = wr_en && addr_hit(wr_addr);
  assign rhit = addr_hit(rd_addr);

  logic wr_ctl, wr_gie, wr_ier, wr_isr, wr_base, rd_ctl, rd_posn;
  assign wr_ctl  = whit && widx == IDX_CTL     && wr_strb[0];
  assign wr_gie  = whit && widx == IDX_IEN_ALL && wr_strb[0];
  assign wr_ier  = whit && widx == IDX_IEN_SRC && wr_strb[0];
  assign wr_isr  = whit && widx == IDX_FLAGS   && wr_strb[0];
  assign wr_base = whit && widx == IDX_BASE;
  assign rd_ctl  = rd_en && rhit && ridx == IDX_CTL;
  assign rd_posn = rd_en && rhit && ridx == IDX_POS_NEW;

  logic start_q, auto_q, done_q, taken_q, gie_q, posf_q;
  logic [N_SRC-1:0]  ier_q, isr_q, ev, flip;
  logic [DATA_W-1:0] pos_q;

  assign ev   = {job_taken, job_done};
  assign flip = wr_isr ? wr_data[N_SRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      auto_q  <= 1'b0;
      done_q  <= 1'b0;
      taken_q <= 1'b0;
      gie_q   <= 1'b0;
      ier_q   <= '0;
      isr_q   <= '0;
      pos_q   <= '0;
      posf_q  <= 1'b0;
    end else begin
      if (job_taken && !auto_q)     start_q <= 1'b0;
      if (wr_ctl && wr_data[B_GO])  start_q <= 1'b1;
      if (wr_ctl)                   auto_q  <= wr_data[B_AUTO];
      if (rd_ctl) begin
        done_q  <= 1'b0;
        taken_q <= 1'b0;
      end
      if (job_done)  done_q  <= 1'b1;
      if (job_taken) taken_q <= 1'b1;
      if (wr_gie) gie_q <= wr_data[0];
      if (wr_ier) ier_q <= wr_data[N_SRC-1:0];
      isr_q <= (isr_q ^ flip) | ev;
      if (coord_vld) pos_q <= coord_data;
      if (rd_posn)   posf_q <= 1'b0;
      if (coord_vld) posf_q <= 1'b1;
    end
  end

  for (genvar b = 0; b < STRB_W; b++) begin : g_base_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst)                          byte_q <= '0;
      else if (wr_base && wr_strb[b])   byte_q <= wr_data[8*b +: 8];
    end
    assign frame_base[8*b +: 8] = byte_q;
  end

  always_comb begin
    rd_data = '0;
    if (rhit) begin
      case (ridx)
        IDX_CTL: begin
          rd_data[B_GO]    = start_q;
          rd_data[B_FIN]   = done_q;
          rd_data[B_IDLE]  = core_idle;
          rd_data[B_TAKEN] = taken_q;
          rd_data[B_AUTO]  = auto_q;
          rd_data[B_IRQ]   = irq;
        end
        IDX_IEN_ALL: rd_data[0] = gie_q;
        IDX_IEN_SRC: rd_data[N_SRC-1:0] = ier_q;
        IDX_FLAGS:   rd_data[N_SRC-1:0] = isr_q;
        IDX_BASE:    rd_data = frame_base;
        IDX_POS:     rd_data = pos_q;
        IDX_POS_NEW: rd_data[0] = posf_q;
        default:     rd_data = '0;
      endcase
    end
  end

  assign core_start = start_q;
  assign gie = gie_q;
  assign ier = ier_q;
  assign isr = isr_q;
endmodule

// File: rtl/csr_irq.sv
module csr_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         gie,
  input  logic [N-1:0] ier,
  input  logic [N-1:0] isr,
  output logic         irq
);
  logic irq_q;
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= gie && |(isr & ier);
  end
  assign irq = irq_q;
endmodule

// File: rtl/ctrl_regs_axil.sv
module ctrl_regs_axil
  import csr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  input  logic              job_done,
  input  logic              job_taken,
  input  logic              core_idle,
  input  logic [DATA_W-1:0] coord_data,
  input  logic              coord_vld,
  output logic              core_start,
  output logic [DATA_W-1:0] frame_base,
  output logic              irq
);
  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [STRB_W-1:0] wr_strb;
  logic              gie_w;
  logic [N_SRC-1:0]  ier_w, isr_w;

  assign s_bresp = RESP_OKAY;
  assign s_rresp = RESP_OKAY;

  csr_axil_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  csr_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .job_done(job_done), .job_taken(job_taken), .core_idle(core_idle),
    .coord_data(coord_data), .coord_vld(coord_vld), .irq(irq),
    .core_start(core_start), .frame_base(frame_base),
    .gie(gie_w), .ier(ier_w), .isr(isr_w)
  );

  csr_irq #(.N(N_SRC)) u_irq (
    .clk(clk), .rst(rst), .gie(gie_w), .ier(ier_w), .isr(isr_w), .irq(irq)
  );
endmodule

// File: rtl/csr_chk.sv
module csr_chk #(
  parameter int DATA_W = 32,
  parameter int N = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic [1:0]        s_bresp,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [1:0]        s_rresp,
  input logic [DATA_W-1:0] s_rdata,
  input logic              job_done,
  input logic              job_taken,
  input logic              gie,
  input logic [N-1:0]      isr,
  input logic              irq
);
  a_r1_bvalid_hold: assert property (@(posedge clk) disable iff (rst)
    s_bvalid && !s_bready |=> s_bvalid);
  a_r1_rvalid_hold: assert property (@(posedge clk) disable iff (rst)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
  a_r1_okay: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid || s_rvalid) |-> (s_bresp == 2'b00 && s_rresp == 2'b00));
  a_r7_done_sets: assert property (@(posedge clk) disable iff (rst)
    job_done |=> isr[0]);
  a_r7_taken_sets: assert property (@(posedge clk) disable iff (rst)
    job_taken |=> isr[1]);
  a_r8_master_mask: assert property (@(posedge clk) disable iff (rst)
    !gie |=> !irq);
endmodule

bind ctrl_regs_axil csr_chk #(.DATA_W(DATA_W), .N(csr_pkg::N_SRC)) u_chk (
  .clk(clk), .rst(rst),
  .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rresp(s_rresp), .s_rdata(s_rdata),
  .job_done(job_done), .job_taken(job_taken),
  .gie(gie_w), .isr(isr_w), .irq(irq)
);

// File: tb/ctrl_regs_axil_test.sv
module ctrl_regs_axil_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int WD_CYCLES = 20000;

  logic clk = 0, rst = 1;
  logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, arvalid = 0;
  logic [DATA_W-1:0] wdata = '0;
  logic [3:0] wstrb = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [DATA_W-1:0] rdata;
  logic job_done = 0, job_taken = 0, core_idle = 1, coord_vld = 0;
  logic [DATA_W-1:0] coord_data = '0;
  logic core_start, irq;
  logic [DATA_W-1:0] frame_base;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_regs_axil #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(1'b1),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(1'b1),
    .job_done(job_done), .job_taken(job_taken), .core_idle(core_idle),
    .coord_data(coord_data), .coord_vld(coord_vld),
    .core_start(core_start), .frame_base(frame_base), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    awaddr = a[ADDR_W-1:0]; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
    do begin @(posedge clk); #1; end while (!awready);
    @(posedge clk); #1;
    awvalid = 0; wvalid = 0;
    chk(bvalid && bresp == 2'b00, "R1 write response", {bvalid, 29'd0, bresp}, 32'h8000_0000);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    araddr = a[ADDR_W-1:0]; arvalid = 1;
    do begin @(posedge clk); #1; end while (!arready);
    @(posedge clk); #1;
    arvalid = 0;
    chk(rvalid && rresp == 2'b00, "R1 read response", {rvalid, 29'd0, rresp}, 32'h8000_0000);
    d = rdata;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic pulse_done();
    @(negedge clk); job_done = 1; @(negedge clk); job_done = 0;
  endtask
  task automatic pulse_taken();
    @(negedge clk); job_taken = 1; @(negedge clk); job_taken = 0;
  endtask
  task automatic pulse_coord();
    @(negedge clk); coord_vld = 1; @(negedge clk); coord_vld = 0;
  endtask

  // {is_write, addr[7:0], data[31:0], expected[31:0]}
  localparam bit [72:0] VEC [12] = '{
    {1'b1, 8'h10, 32'hDEAD_BEEF, 32'h0},
    {1'b0, 8'h10, 32'h0,         32'hDEAD_BEEF},   // R2
    {1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h04, 32'h0,         32'h0000_0001},   // R6
    {1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h08, 32'h0,         32'h0000_0003},   // R6
    {1'b1, 8'h14, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h14, 32'h0,         32'h0},           // R10
    {1'b1, 8'h12, 32'h1234_5678, 32'h0},
    {1'b0, 8'h10, 32'h0,         32'hDEAD_BEEF},   // R10 unaligned write ignored
    {1'b1, 8'h04, 32'h0,         32'h0},
    {1'b1, 8'h08, 32'h0,         32'h0}
  };

  initial begin : wdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=0x00000000 exp=0x00000001");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(core_start == 0, "R3 reset start", {31'd0, core_start}, 0);
    chk(irq == 0, "R8 reset irq", {31'd0, irq}, 0);
    chk(!bvalid && !rvalid, "R1 reset valids", {30'd0, bvalid, rvalid}, 0);
    chk(frame_base == 0, "R2 reset base", frame_base, 0);
    rd_chk(8'h00, 32'h4, "R5 reset ctl idle");

    for (int i = 0; i < 12; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32], 4'hF);
      else rd_chk(VEC[i][71:64], VEC[i][31:0], "R2/R6/R10 table");
    end
    rd_chk(8'h0C, 32'h0, "R7 status idle");
    rd_chk(8'h18, 32'h0, "R9 pos reset");
    rd_chk(8'h1C, 32'h0, "R9 flag reset");
    chk(frame_base == 32'hDEAD_BEEF, "R2 base port", frame_base, 32'hDEAD_BEEF);

    wr(8'h10, 32'hAABB_CCDD, 4'b0101);
    rd_chk(8'h10, 32'hDEBB_BEDD, "R2 byte strobes");
    chk(frame_base == 32'hDEBB_BEDD, "R2 strobe port", frame_base, 32'hDEBB_BEDD);

    core_idle = 0;
    wr(8'h00, 32'h1, 4'hF);
    @(negedge clk);
    chk(core_start == 1, "R3 start set", {31'd0, core_start}, 1);
    rd_chk(8'h00, 32'h1, "R3 ctl start bit");
    pulse_taken();
    chk(core_start == 0, "R3 start cleared by accept", {31'd0, core_start}, 0);
    rd_chk(8'h00, 32'h8, "R5 accept flag");
    rd_chk(8'h00, 32'h0, "R5 accept flag cleared on read");

    wr(8'h00, 32'h1, 4'hF);
    wr(8'h00, 32'h0, 4'hF);
    @(negedge clk);
    chk(core_start == 1, "R3 write 0 ignored", {31'd0, core_start}, 1);
    pulse_taken();
    rd_chk(8'h00, 32'h8, "R3 clear after accept");

    wr(8'h00, 32'h81, 4'hF);
    pulse_taken();
    chk(core_start == 1, "R4 auto keeps start", {31'd0, core_start}, 1);
    rd_chk(8'h00, 32'h89, "R4 ctl auto");
    rd_chk(8'h00, 32'h81, "R5 accept cleared, R4 auto held");
    wr(8'h00, 32'h0, 4'hF);
    pulse_taken();
    chk(core_start == 0, "R4 clear once auto off", {31'd0, core_start}, 0);
    rd_chk(8'h00, 32'h8, "R4 ctl after auto off");

    pulse_done();
    rd_chk(8'h00, 32'h2, "R5 done flag");
    rd_chk(8'h00, 32'h0, "R5 done cleared on read");
    rd_chk(8'h0C, 32'h3, "R7 status set without enables");
    chk(irq == 0, "R8 no enables", {31'd0, irq}, 0);
    wr(8'h0C, 32'h3, 4'hF);
    rd_chk(8'h0C, 32'h0, "R7 toggle clears");

    wr(8'h08, 32'h1, 4'hF);
    wr(8'h04, 32'h1, 4'hF);
    pulse_done();
    @(negedge clk);
    chk(irq == 1, "R8 irq done source", {31'd0, irq}, 1);
    rd_chk(8'h0C, 32'h1, "R7 status done");
    rd_chk(8'h00, 32'h202, "R8 ctl irq bit");
    wr(8'h0C, 32'h1, 4'hF);
    @(negedge clk); @(negedge clk);
    chk(irq == 0, "R8 irq drops after toggle", {31'd0, irq}, 0);
    wr(8'h0C, 32'h2, 4'hF);
    @(negedge clk); @(negedge clk);
    chk(irq == 0, "R8 source disabled", {31'd0, irq}, 0);
    rd_chk(8'h0C, 32'h2, "R7 toggle sets");
    wr(8'h08, 32'h3, 4'hF);
    @(negedge clk); @(negedge clk);
    chk(irq == 1, "R8 accept source", {31'd0, irq}, 1);
    wr(8'h04, 32'h0, 4'hF);
    @(negedge clk); @(negedge clk);
    chk(irq == 0, "R8 master enable off", {31'd0, irq}, 0);
    wr(8'h0C, 32'h2, 4'hF);
    rd_chk(8'h0C, 32'h0, "R7 toggle clears bit 1");

    coord_data = 32'h00A0_2C05;
    pulse_coord();
    coord_data = 32'h1111_1111;
    rd_chk(8'h1C, 32'h1, "R9 fresh flag");
    rd_chk(8'h1C, 32'h0, "R9 flag cleared on read");
    rd_chk(8'h18, 32'h00A0_2C05, "R9 captured coord");
    wr(8'h18, 32'hFFFF_FFFF, 4'hF);
    rd_chk(8'h18, 32'h00A0_2C05, "R9 coord read-only");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule